// File: doc/BRIEF.md
# Shared Register Select Collision Arbiter

This block sits between a local processor and a register interface that an asynchronous host can also reach. It watches two active-low chip selects: one from the host, which runs on its own timing, and one from the local processor, which is synchronous to the block clock. The local select reaches the shared interface only through a gated output. When the two selects overlap, the block stalls the local processor with an active-low wait request and keeps the gated local select inactive until the host has finished.

The order in which the selects arrive sets the priority. A local access that has already been granted keeps its gated select through any later host select. A local select that meets a host select already in progress is held back, and its processor waits. The block has no host-side output, so it can never delay or block the host. Before the arbitration logic sees the host select, the select passes through a chain of SYNC_STAGES flip-flops (two by default).

Top module: `coll_arbiter`

## Requirements
- R1: While `rst` is high, and in the cycle after reset is released, `loc_sel_gated_n` and `loc_wait_n` are both 1 (inactive).
- R2: When `loc_sel_n` is 0 and the synchronised host select is inactive at a rising edge, `loc_sel_gated_n` is 0 after that edge for as long as `loc_sel_n` stays 0.
- R3: Whenever `loc_sel_n` is 1, `loc_sel_gated_n` is 1 in the same cycle, with no clock edge needed, and the grant is dropped at the next edge.
- R4: If the synchronised host select is active at the edge where an ungranted local select is first seen, the local select is held off: `loc_wait_n` goes to 0 after that edge and `loc_sel_gated_n` stays 1.
- R5: A host select becomes visible to the arbitration after exactly SYNC_STAGES rising edges. With the default of 2, a local select sampled at the second edge after the host select falls is still granted, and one sampled at the third edge is held off.
- R6: At the first rising edge where the synchronised host select is seen inactive, a pending wait is released (`loc_wait_n` goes to 1), and `loc_sel_gated_n` goes to 0 if `loc_sel_n` is still 0.
- R7: Once a local access is granted, a host select that arrives later does not affect it: `loc_sel_gated_n` stays 0 and `loc_wait_n` stays 1 until `loc_sel_n` returns to 1.
- R8: `loc_wait_n` is 0 only if `loc_sel_n` was 0 at the preceding rising edge.
- R9: `loc_sel_gated_n` and `loc_wait_n` are never both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel_n | input | 1 | Host chip select, active low, asynchronous to clk |
| loc_sel_n | input | 1 | Local processor chip select, active low, synchronous to clk |
| loc_sel_gated_n | output | 1 | Local select passed to the shared interface, active low |
| loc_wait_n | output | 1 | Wait request to the local processor, active low |

## Verification
A corrupted grant flag shows up at the ports at once. Either the gated select goes active while a host access is in progress, or a granted access loses its select in the middle of its transfer. The error is visible at the first edge after the faulty state is entered. A stuck hold state leaves the wait request low after the synchronised host select has gone inactive, which is detectable one edge after the release should have occurred. A wrong synchroniser depth moves the grant/hold boundary by whole cycles, and timing a local select against a host select at known distances exposes this.

// File: rtl/coll_arb_pkg.sv
package coll_arb_pkg;

    // Arbitration state of the local side
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,  // no local access seen
        ARB_OWN  = 2'd1,  // local access granted
        ARB_HOLD = 2'd2   // local access stalled behind host
    } arb_state_e;

    // Decoded control flags produced from the state
    typedef struct packed {
        logic granted;
        logic stalled;
    } arb_flags_t;

    // Next state given the local request and the synchronised host request
    function automatic arb_state_e arb_next(input arb_state_e cur,
                                            input logic loc_req,
                                            input logic host_req);
        arb_state_e nxt;
        if (!loc_req) begin
            nxt = ARB_IDLE;
        end else begin
            case (cur)
                ARB_OWN:  nxt = ARB_OWN;
                ARB_HOLD: nxt = host_req ? ARB_HOLD : ARB_OWN;
                default:  nxt = host_req ? ARB_HOLD : ARB_OWN;
            endcase
        end
        return nxt;
    endfunction

    function automatic arb_flags_t arb_decode(input arb_state_e cur);
        arb_flags_t f;
        f.granted = (cur == ARB_OWN);
        f.stalled = (cur == ARB_HOLD);
        return f;
    endfunction

endpackage

// File: rtl/host_sel_sync.sv
module host_sel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_sel_n,
    output logic host_busy
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= async_sel_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign host_busy = ~chain_q[LAST];
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import coll_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       loc_req,
    input  logic       host_req,
    output arb_flags_t flags
);
    arb_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ARB_IDLE;
        else     state_q <= arb_next(state_q, loc_req, host_req);
    end

    assign flags = arb_decode(state_q);
endmodule

// File: rtl/arb_outputs.sv
module arb_outputs
    import coll_arb_pkg::*;
(
    input  logic       loc_req,
    input  arb_flags_t flags,
    output logic       gated_n,
    output logic       wait_n
);
    // Gating uses the live local request so release is immediate
    assign gated_n = ~(loc_req & flags.granted);
    assign wait_n  = ~flags.stalled;
endmodule

// File: rtl/coll_arbiter.sv
module coll_arbiter
    import coll_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic host_sel_n,
    input  logic loc_sel_n,
    output logic loc_sel_gated_n,
    output logic loc_wait_n
);
    logic       host_busy;
    logic       loc_req;
    arb_flags_t flags;

    assign loc_req = ~loc_sel_n;

    host_sel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_sel_n(host_sel_n),
        .host_busy  (host_busy)
    );

    arb_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .loc_req (loc_req),
        .host_req(host_busy),
        .flags   (flags)
    );

    arb_outputs u_out (
        .loc_req(loc_req),
        .flags  (flags),
        .gated_n(loc_sel_gated_n),
        .wait_n (loc_wait_n)
    );
endmodule

// File: rtl/coll_arbiter_chk.sv
module coll_arbiter_chk (
    input logic clk,
    input logic rst,
    input logic loc_sel_n,
    input logic host_busy,
    input logic loc_sel_gated_n,
    input logic loc_wait_n
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (loc_sel_gated_n && loc_wait_n));

    // R2
    free_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (!loc_sel_n && !host_busy) |=> (loc_sel_n || !loc_sel_gated_n));

    // R3
    idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
        loc_sel_n |-> loc_sel_gated_n);

    // R4
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!loc_sel_n && host_busy && loc_sel_gated_n)
        |=> (loc_sel_n || (loc_sel_gated_n && !loc_wait_n)));

    // R7
    keep_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !loc_sel_gated_n |=> (loc_sel_n || (!loc_sel_gated_n && loc_wait_n)));

    // R8
    wait_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !loc_wait_n |-> $past(!loc_sel_n));

    // R9
    exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        (loc_sel_gated_n || loc_wait_n));
endmodule

bind coll_arbiter coll_arbiter_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .loc_sel_n      (loc_sel_n),
    .host_busy      (host_busy),
    .loc_sel_gated_n(loc_sel_gated_n),
    .loc_wait_n     (loc_wait_n)
);

// File: tb/coll_arbiter_bench.sv
module coll_arbiter_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_sel_n = 1'b1;
    logic loc_sel_n = 1'b1;
    logic loc_sel_gated_n;
    logic loc_wait_n;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    coll_arbiter u_coll_arbiter (
        .clk            (clk),
        .rst            (rst),
        .host_sel_n     (host_sel_n),
        .loc_sel_n      (loc_sel_n),
        .loc_sel_gated_n(loc_sel_gated_n),
        .loc_wait_n     (loc_wait_n)
    );

    // Each row: {host_sel_n, loc_sel_n, expected gated_n, expected wait_n}
    // Driven at the falling edge, checked just after the next rising edge.
    localparam int NV = 20;
    localparam logic [3:0] VEC [NV] = '{
        4'b1111, // idle
        4'b1001, // R2 free grant
        4'b1001, // R2 held
        4'b1111, // R3 release
        4'b0111, // host enters sync
        4'b0111, // host visible
        4'b0010, // R4 held off, wait
        4'b0010, // R4
        4'b1010, // host leaving sync
        4'b1010, // still seen busy
        4'b1001, // R6 release and grant
        4'b0001, // host arrives during grant
        4'b0001, // R7
        4'b0001, // R7
        4'b0111, // local ends
        4'b0010, // R4 again
        4'b0111, // R8 local drops while held
        4'b1111,
        4'b1111,
        4'b1111
    };

    task automatic check(input string req, input logic act_g, input logic act_w,
                         input logic exp_g, input logic exp_w);
        checks++;
        if (act_g !== exp_g || act_w !== exp_w) begin
            fails++;
            $display("FAIL %s: gated_n/wait_n actual %b%b expected %b%b",
                     req, act_g, act_w, exp_g, exp_w);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic h, input logic l);
        @(negedge clk);
        host_sel_n = h;
        loc_sel_n = l;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #2 check("R1 during reset", loc_sel_gated_n, loc_wait_n, 1'b1, 1'b1);
        drive(1'b1, 1'b1);
        rst = 1'b0;
        step();
        check("R1 after reset", loc_sel_gated_n, loc_wait_n, 1'b1, 1'b1);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][3], VEC[i][2]);
            step();
            check($sformatf("vector %0d (R2 R3 R4 R6 R7 R8 R9)", i),
                  loc_sel_gated_n, loc_wait_n, VEC[i][1], VEC[i][0]);
        end

        // R3: gated release without waiting for an edge
        drive(1'b1, 1'b0);
        step();
        check("R3 granted", loc_sel_gated_n, loc_wait_n, 1'b0, 1'b1);
        drive(1'b1, 1'b1);
        #1 check("R3 same-cycle release", loc_sel_gated_n, loc_wait_n, 1'b1, 1'b1);
        step();
        step();

        // R5 case A: local seen at second edge after host falls -> granted
        drive(1'b0, 1'b1);
        step();
        drive(1'b0, 1'b0);
        step();
        check("R5 second edge still granted", loc_sel_gated_n, loc_wait_n, 1'b0, 1'b1);
        drive(1'b1, 1'b1);
        repeat (4) step();
        check("R5 settle", loc_sel_gated_n, loc_wait_n, 1'b1, 1'b1);

        // R5 case B: local seen at third edge -> held off
        drive(1'b0, 1'b1);
        step();
        step();
        drive(1'b0, 1'b0);
        step();
        check("R5 third edge held off", loc_sel_gated_n, loc_wait_n, 1'b1, 1'b0);

        // R1: reset in the middle of a hold
        @(negedge clk) rst = 1'b1;
        step();
        check("R1 reset clears hold", loc_sel_gated_n, loc_wait_n, 1'b1, 1'b1);
        drive(1'b1, 1'b1);
        rst = 1'b0;
        repeat (3) step();

        // R6: long host access, release exactly after sync delay
        drive(1'b0, 1'b1);
        repeat (3) step();
        drive(1'b0, 1'b0);
        step();
        check("R6 stalled", loc_sel_gated_n, loc_wait_n, 1'b1, 1'b0);
        repeat (5) step();
        check("R6 still stalled", loc_sel_gated_n, loc_wait_n, 1'b1, 1'b0);
        drive(1'b1, 1'b0);
        step();
        step();
        check("R6 not yet released", loc_sel_gated_n, loc_wait_n, 1'b1, 1'b0);
        step();
        check("R6 released", loc_sel_gated_n, loc_wait_n, 1'b0, 1'b1);
        drive(1'b1, 1'b1);
        step();
        check("R8 idle no wait", loc_sel_gated_n, loc_wait_n, 1'b1, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule